// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Parallel Receiver

This block turns a one-bit serial stream, clocked by a bit clock, into ten-bit characters for the parallel side of a link that uses 8b/10b coding. It produces a pair of complementary byte clocks at one tenth of the bit rate. Each new character appears on the rising edge of the primary byte clock, so a downstream stage can capture it on the following rising edge.

A detector watches the seven most recent bits for either polarity of the comma. When alignment is enabled and a comma shows up off the current word boundary, the boundary moves so that the comma's first bit becomes bit 0 of a character. The byte clock phase restarts from the new boundary. A one-byte-period flag marks each character whose leading seven bits hold a comma. A loopback select replaces the line input with the local transmit stream. Clock recovery and any analog front end sit outside the block; the bit clock is an input.

Top module: `comma_align_rx`

## Requirements
- R1: The first bit received for a character lands on `char_out[0]` and the last on `char_out[9]`. Bits 0..9 carry the code letters a, b, c, d, e, i, f, g, h, j. Directly after reset release, the first bit clocked in is bit 0 of a character.
- R2: `byte_clk` has a period of ten bit clocks. After the edge that completes a character, it is high for five bit clocks and then low for five. `char_out` changes only on the bit-clock edge where `byte_clk` rises.
- R3: `byte_clk_n` is always the inverse of `byte_clk` outside reset.
- R4: A comma is seven consecutive bits, oldest first: 0011111 (positive) or 1100000 (negative).
- R5: With `align_en` high, a comma whose first bit is not at bit 0 causes realignment. The character beginning with that comma is output within 20 bit clocks of the comma's last bit (3 bit clocks in this design), and `byte_clk` is low on the cycle after the realignment.
- R6: With `align_en` low, the word boundary never moves, even when a comma arrives off the boundary.
- R7: `comma_seen` is high for exactly one byte period (ten bit clocks) for each output character whose bits 0..6 hold a comma, and low for all other characters.
- R8: With `loop_en` high, characters are assembled from `loop_bit` and `line_bit` has no effect. With `loop_en` low, `line_bit` is used.
- R9: A synchronous reset, sampled on `clk`, sets `char_out` to zero, `comma_seen` low, `byte_clk` high and `byte_clk_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| line_bit | input | 1 | Serial data from the line |
| loop_bit | input | 1 | Serial data from the local transmitter |
| loop_en | input | 1 | 1 selects `loop_bit` as the source |
| align_en | input | 1 | 1 allows comma-driven realignment |
| char_out | output | 10 | Assembled character, bit 0 received first |
| comma_seen | output | 1 | Current character starts with a comma |
| byte_clk | output | 1 | Primary byte clock |
| byte_clk_n | output | 1 | Inverted byte clock |

## Verification
A wrong phase count makes the boundary drift at the ports. Characters then come out shifted against the sent words and `byte_clk` edges slip, both within one character time of the fault. A wrong comma window or wrong polarity shows as a missing or spurious `comma_seen` together with a misframed character, at the first character after the comma. A source-select error corrupts the very next character. A stuck flag register shows as `comma_seen` outliving its ten-cycle window.

// File: rtl/carx_pkg.sv
package carx_pkg;
  localparam int WORD_W  = 10;
  localparam int COMMA_W = 7;
  localparam int PH_W    = $clog2(WORD_W);
  localparam int HIGH_N  = WORD_W / 2;

  // Patterns stored with the oldest bit at index 0.
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b1111100;
  localparam logic [COMMA_W-1:0] COMMA_NEG = 7'b0000011;

  function automatic logic is_comma(input logic [COMMA_W-1:0] w);
    return (w == COMMA_POS) || (w == COMMA_NEG);
  endfunction

  function automatic logic [PH_W-1:0] ph_advance(input logic [PH_W-1:0] p);
    return (p == PH_W'(WORD_W - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic in_high_half(input logic [PH_W-1:0] p);
    return p < PH_W'(HIGH_N);
  endfunction
endpackage

// File: rtl/carx_bit_window.sv
module carx_bit_window
  import carx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_bit,
  input  logic              loop_bit,
  input  logic              loop_en,
  output logic              bit_now,
  output logic [WORD_W-1:0] win,
  output logic              comma_hit
);
  // Source select for the loopback path (R8)
  always_comb bit_now = loop_en ? loop_bit : line_bit;

  // Newest bit enters at the top; win[0] is the oldest
  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {bit_now, win[WORD_W-1:1]};
  end

  // The seven newest bits, oldest of them at index 0 (R4)
  always_comb comma_hit = is_comma(win[WORD_W-1 -: COMMA_W]);

  // R4: a comma cannot repeat after a single shift
  a_r4_comma_isolated: assert property (@(posedge clk) disable iff (rst)
    comma_hit |=> !comma_hit);
endmodule

// File: rtl/carx_phase_ctrl.sv
module carx_phase_ctrl
  import carx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic align_en,
  input  logic comma_hit,
  output logic word_done,
  output logic byte_clk,
  output logic byte_clk_n
);
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] eff_ph;
  logic [PH_W-1:0] nxt_ph;
  logic            realign;

  // A comma just completed means the incoming bit is index COMMA_W
  always_comb begin
    realign   = align_en && comma_hit;
    eff_ph    = realign ? PH_W'(COMMA_W) : phase;
    nxt_ph    = ph_advance(eff_ph);
    word_done = (eff_ph == PH_W'(WORD_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      byte_clk   <= 1'b1;
      byte_clk_n <= 1'b0;
    end else begin
      phase      <= nxt_ph;
      byte_clk   <= in_high_half(nxt_ph);
      byte_clk_n <= !in_high_half(nxt_ph);
    end
  end

  // R3: complementary pair
  a_r3_clk_pair: assert property (@(posedge clk) disable iff (rst)
    byte_clk != byte_clk_n);

  // R5: byte clock restarts low after a realignment
  a_r5_realign_restart: assert property (@(posedge clk) disable iff (rst)
    realign |=> !byte_clk);

  // R2: byte clock rises only when a word has completed
  a_r2_rise_on_word: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_clk) |-> $past(word_done));
endmodule

// File: rtl/carx_word_reg.sv
module carx_word_reg
  import carx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic              bit_now,
  input  logic [WORD_W-1:1] win_hi,
  output logic [WORD_W-1:0] char_out,
  output logic              comma_seen
);
  logic [WORD_W-1:0] full_word;

  always_comb full_word = {bit_now, win_hi};

  always_ff @(posedge clk) begin
    if (rst) begin
      char_out   <= '0;
      comma_seen <= 1'b0;
    end else if (word_done) begin
      char_out   <= full_word;
      comma_seen <= is_comma(full_word[COMMA_W-1:0]);
    end
  end

  // R7: flag only with a comma-led character
  a_r7_flag_is_comma: assert property (@(posedge clk) disable iff (rst)
    comma_seen |-> is_comma(char_out[COMMA_W-1:0]));

  // R9: reset leaves a cleared word and flag
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (char_out == '0 && !comma_seen));
endmodule

// File: rtl/comma_align_rx.sv
module comma_align_rx
  import carx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_bit,
  input  logic              loop_bit,
  input  logic              loop_en,
  input  logic              align_en,
  output logic [WORD_W-1:0] char_out,
  output logic              comma_seen,
  output logic              byte_clk,
  output logic              byte_clk_n
);
  logic              bit_now;
  logic [WORD_W-1:0] win;
  logic              comma_hit;
  logic              word_done;

  carx_bit_window u_win (
    .clk       (clk),
    .rst       (rst),
    .line_bit  (line_bit),
    .loop_bit  (loop_bit),
    .loop_en   (loop_en),
    .bit_now   (bit_now),
    .win       (win),
    .comma_hit (comma_hit)
  );

  carx_phase_ctrl u_ph (
    .clk        (clk),
    .rst        (rst),
    .align_en   (align_en),
    .comma_hit  (comma_hit),
    .word_done  (word_done),
    .byte_clk   (byte_clk),
    .byte_clk_n (byte_clk_n)
  );

  carx_word_reg u_word (
    .clk        (clk),
    .rst        (rst),
    .word_done  (word_done),
    .bit_now    (bit_now),
    .win_hi     (win[WORD_W-1:1]),
    .char_out   (char_out),
    .comma_seen (comma_seen)
  );

  // R2: data holds except at a byte clock rise
  a_r2_data_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$rose(byte_clk) |-> $stable(char_out));

  // R7: flag holds for the whole byte period
  a_r7_flag_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$rose(byte_clk) |-> $stable(comma_seen));
endmodule

// File: tb/comma_align_rx_tb_top.sv
`timescale 1ns/1ps
module comma_align_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_bit = 1'b0;
  logic       loop_bit = 1'b0;
  logic       loop_en = 1'b0;
  logic       align_en = 1'b0;
  logic [9:0] char_out;
  logic       comma_seen;
  logic       byte_clk;
  logic       byte_clk_n;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  comma_align_rx dut_i (
    .clk(clk), .rst(rst), .line_bit(line_bit), .loop_bit(loop_bit),
    .loop_en(loop_en), .align_en(align_en), .char_out(char_out),
    .comma_seen(comma_seen), .byte_clk(byte_clk), .byte_clk_n(byte_clk_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the falling edge after capture
  task automatic send_bit(input logic lb, input logic kb);
    line_bit = lb;
    loop_bit = kb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [9:0] w, input int n);
    for (int k = 0; k < n; k++) send_bit(w[k], 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Word sent from the boundary, checking clocks and data hold per bit
  task automatic send_word_checked(input logic [9:0] w, input logic [9:0] prev);
    for (int k = 0; k < 10; k++) begin
      send_bit(w[k], 1'b0);
      chk(byte_clk == ((k == 9) || (k <= 3)), "R2", "byte_clk phase",
          32'(byte_clk), 32'((k == 9) || (k <= 3)));
      chk(byte_clk_n == !byte_clk, "R3", "byte_clk_n inverse",
          32'(byte_clk_n), 32'(!byte_clk));
      if (k < 9) chk(char_out == prev, "R2", "data held mid-word",
                     32'(char_out), 32'(prev));
    end
    chk(char_out == w, "R1", "bit order", 32'(char_out), 32'(w));
  endtask

  task automatic t_reset();
    do_reset();
    rst = 1'b1;
    @(negedge clk);
    chk(char_out == 10'h000, "R9", "reset word", 32'(char_out), 32'h0);
    chk(comma_seen == 1'b0, "R9", "reset flag", 32'(comma_seen), 32'h0);
    chk(byte_clk == 1'b1 && byte_clk_n == 1'b0, "R9", "reset clocks",
        32'({byte_clk, byte_clk_n}), 32'h2);
    rst = 1'b0;
  endtask

  task automatic t_order();
    align_en = 1'b0;
    do_reset();
    send_word_checked(10'h2B5, 10'h000);
    send_word_checked(10'h19C, 10'h2B5);
    send_word_checked(10'h2AA, 10'h19C);
  endtask

  task automatic t_align();
    int hi_cnt;
    align_en = 1'b1;
    do_reset();
    send_bits(10'b0000000010, 3);          // filler 0,1,0
    send_bits(10'h17C, 7);                 // positive comma, off boundary
    send_bits(10'h17C >> 7, 3);            // g,h,j
    chk(char_out == 10'h17C, "R5", "realigned positive comma word",
        32'(char_out), 32'h17C);
    chk(comma_seen == 1'b1, "R4", "positive comma flagged",
        32'(comma_seen), 32'h1);
    hi_cnt = 1;
    for (int k = 0; k < 10; k++) begin
      send_bit(10'h2B5 >> k, 1'b0);
      if (comma_seen) hi_cnt++;
    end
    chk(hi_cnt == 10, "R7", "flag high one byte period", 32'(hi_cnt), 32'd10);
    chk(char_out == 10'h2B5, "R5", "word after realign", 32'(char_out), 32'h2B5);
    chk(comma_seen == 1'b0, "R7", "flag clears on plain word",
        32'(comma_seen), 32'h0);
    send_bits(10'b0000001010, 5);          // filler 0,1,0,1,0
    send_bits(10'h283, 10);                // negative comma, off boundary
    chk(char_out == 10'h283, "R4", "realigned negative comma word",
        32'(char_out), 32'h283);
    chk(comma_seen == 1'b1, "R4", "negative comma flagged",
        32'(comma_seen), 32'h1);
    // mid-run reset
    rst = 1'b1;
    @(negedge clk);
    chk(char_out == 10'h000 && comma_seen == 1'b0, "R9", "mid-run reset",
        32'({comma_seen, char_out}), 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_noalign();
    align_en = 1'b0;
    do_reset();
    send_bits(10'b0000000010, 3);
    send_bits(10'h17C, 7);
    chk(char_out == 10'h3E2, "R6", "boundary word kept", 32'(char_out), 32'h3E2);
    chk(comma_seen == 1'b0, "R7", "no flag off boundary", 32'(comma_seen), 32'h0);
    send_bits(10'h17C >> 7, 3);
    chk(char_out == 10'h3E2, "R6", "no realign output", 32'(char_out), 32'h3E2);
    send_bits(10'h2B5, 7);
    chk(char_out == 10'h1AA, "R6", "old framing next word", 32'(char_out), 32'h1AA);
    chk(comma_seen == 1'b0, "R7", "still no flag", 32'(comma_seen), 32'h0);
  endtask

  task automatic t_loop();
    logic [9:0] w;
    align_en = 1'b0;
    loop_en = 1'b1;
    do_reset();
    w = 10'h19C;
    for (int k = 0; k < 10; k++) send_bit(!w[k], w[k]);
    chk(char_out == 10'h19C, "R8", "loopback source", 32'(char_out), 32'h19C);
    loop_en = 1'b0;
    w = 10'h2AA;
    for (int k = 0; k < 10; k++) send_bit(w[k], !w[k]);
    chk(char_out == 10'h2AA, "R8", "line source", 32'(char_out), 32'h2AA);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_order();
    t_align();
    t_noalign();
    t_loop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule